// File: doc/BRIEF.md
# Centralized Bus Arbiter with Grant Parking

This block arbitrates a single shared bus among a parameterised number of masters. Each master has its own request line and its own grant line. A master may drive the bus only while its grant is high. The master, or the bus it drives, signals completion on a shared bus-idle line. While a transaction is still running, the arbiter already chooses the next owner by round robin, starting after the most recent owner. The chosen owner takes over on a cycle in which the bus is idle.

When nobody else is asking, the grant stays with the last owner. That owner can then start another transfer without waiting for arbitration. The arbiter also prevents lockout. If an owner keeps the bus busy for more than `HOLD_LIMIT` cycles while another master waits, the arbiter withdraws the grant. It then hands the bus over at the next idle cycle.

Top module: `bus_park_arbiter`

## Requirements
- R1: While reset is asserted, and after its release with no requests, `gnt_o` is 4'b0001 for the default of four masters (master 0 owns the parked grant) and `gnt_id_o` is 0.
- R2: In every cycle, at most one bit of `gnt_o` is high.
- R3: The grant moves to a different master only at a rising edge whose preceding cycle had `bus_idle_i` high. A request from another master while the bus is busy, within the hold limit, leaves the grant unchanged.
- R4: Take a master that is not the owner. If its request and `bus_idle_i` are both high before a rising edge and stay high, its grant appears at the second rising edge: the first edge records the choice and the second transfers the grant.
- R5: The next owner is the first requesting master found in increasing index order after the current owner, wrapping from N-1 to 0. The current owner is never chosen against itself.
- R6: If no master other than the owner requests, the grant stays with the owner whether or not the owner requests and whether or not the bus is idle.
- R7: A choice whose request has dropped by the handover edge is not granted. A withdrawn grant whose waiting master has gone away returns to the previous owner at the next idle cycle.
- R8: Suppose the grant went to a master at edge E, another master has requested since edge E+1, and the bus has stayed busy. Then `gnt_o` still shows that owner after edge E+HOLD_LIMIT and becomes all zero at edge E+HOLD_LIMIT+1. `gnt_id_o` keeps the previous owner's index.
- R9: Once a grant has been withdrawn, the first idle cycle hands the grant to the waiting master at the following edge.
- R10: After a grant moves from one master to another, it stays unchanged for at least the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_MASTERS | One request bit per master |
| bus_idle_i | input | 1 | High when the bus is idle or the current transfer ends this cycle |
| gnt_o | output | N_MASTERS | One-hot (or all-zero when withdrawn) grant vector |
| gnt_id_o | output | IDW | Index of the most recent owner |

## Verification
Every result has a fixed delay. A choice is registered at the first edge after a request becomes visible, and the grant moves at the next idle edge, so a fresh request with the bus idle shows up two edges later. A withdrawal lands HOLD_LIMIT+1 edges after the grant it ends, and the handover after a withdrawal follows one edge after idle rises. The bench drives inputs after a falling edge, advances whole cycles, and samples outputs at the falling edge after the exact edge counted for each result. It also samples one cycle before each due edge, to show that nothing happens early.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

    // Whether the most recent owner still holds its grant line.
    typedef enum logic {
        OWN_ACTIVE  = 1'b0,
        OWN_REVOKED = 1'b1
    } own_mode_e;

endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N_MASTERS = 4,
    localparam int IDW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic [N_MASTERS-1:0] req,
    input  logic [IDW-1:0]       last,
    output logic [IDW-1:0]       pick,
    output logic                 vld
);

    // Search starts one past the last owner and wraps; the owner itself is skipped.
    always_comb begin
        pick = '0;
        vld  = 1'b0;
        for (int k = 1; k < N_MASTERS; k++) begin
            int unsigned s;
            logic [IDW-1:0] idx;
            s = int'(last) + k;
            if (s >= N_MASTERS) s = s - N_MASTERS;
            idx = IDW'(s);
            if (!vld && req[idx]) begin
                pick = idx;
                vld  = 1'b1;
            end
        end
    end

    always_comb begin
        if (vld) begin
            assert_pick_req_R5: assert (req[pick] && (pick != last))
                else $error("chosen master is not requesting or equals owner");
        end
    end

endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
    parameter int HOLD_LIMIT = 8,
    localparam int CW = $clog2(HOLD_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic expired
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (en && (cnt_q < CW'(HOLD_LIMIT)))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q >= CW'(HOLD_LIMIT));

    assert_hold_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(HOLD_LIMIT))
        else $error("hold counter past its limit");

endmodule

// File: rtl/bus_park_arbiter.sv
module bus_park_arbiter
    import bus_arb_pkg::*;
#(
    parameter int N_MASTERS  = 4,
    parameter int HOLD_LIMIT = 8,
    localparam int IDW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_MASTERS-1:0] req_i,
    input  logic                 bus_idle_i,
    output logic [N_MASTERS-1:0] gnt_o,
    output logic [IDW-1:0]       gnt_id_o
);

    typedef struct packed {
        logic [N_MASTERS-1:0] gnt;
        logic [IDW-1:0]       owner;
        own_mode_e            mode;
        logic [IDW-1:0]       pick;
        logic                 pick_vld;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [IDW-1:0] rr_idx;
    logic           rr_vld;
    logic           hold_expired;
    logic           chg;
    logic           pick_live;

    rr_pick #(.N_MASTERS(N_MASTERS)) u_pick (
        .req  (req_i),
        .last (st_q.owner),
        .pick (rr_idx),
        .vld  (rr_vld)
    );

    hold_timer #(.HOLD_LIMIT(HOLD_LIMIT)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (chg),
        .en      (st_q.mode == OWN_ACTIVE),
        .expired (hold_expired)
    );

    always_comb begin
        st_d      = st_q;
        chg       = 1'b0;
        // A registered choice counts only if its master still asks for the bus.
        pick_live = st_q.pick_vld && req_i[st_q.pick];

        // Overlapped arbitration: next choice is refreshed every cycle.
        st_d.pick     = rr_idx;
        st_d.pick_vld = rr_vld;

        if (bus_idle_i) begin
            if (pick_live) begin
                st_d.gnt            = '0;
                st_d.gnt[st_q.pick] = 1'b1;
                st_d.owner          = st_q.pick;
                st_d.mode           = OWN_ACTIVE;
                chg                 = 1'b1;
            end else if (st_q.mode == OWN_REVOKED) begin
                st_d.gnt             = '0;
                st_d.gnt[st_q.owner] = 1'b1;
                st_d.mode            = OWN_ACTIVE;
                chg                  = 1'b1;
            end
        end else if ((st_q.mode == OWN_ACTIVE) && hold_expired && pick_live) begin
            st_d.gnt  = '0;
            st_d.mode = OWN_REVOKED;
        end

        // The choice was made against the old owner; redo it next cycle.
        if (chg) st_d.pick_vld = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.gnt      <= {{(N_MASTERS-1){1'b0}}, 1'b1};
            st_q.owner    <= '0;
            st_q.mode     <= OWN_ACTIVE;
            st_q.pick     <= '0;
            st_q.pick_vld <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_o    = st_q.gnt;
    assign gnt_id_o = st_q.owner;

    assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o))
        else $error("more than one grant");

    assert_move_on_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(gnt_o) && (gnt_o != '0)) |-> $past(bus_idle_i))
        else $error("grant moved while bus busy");

    assert_revoke_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_o == '0) && ($past(gnt_o) != '0)) |-> ($past(hold_expired) && !$past(bus_idle_i)))
        else $error("grant withdrawn without expired hold");

    assert_min_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(gnt_o) && (gnt_o != '0) && ($past(gnt_o) != '0)) |=> $stable(gnt_o))
        else $error("grant moved twice in a row");

    assert_id_matches_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0) |-> gnt_o[gnt_id_o])
        else $error("grant index disagrees with grant vector");

endmodule

// File: tb/sim_bus_park_arbiter.sv
module sim_bus_park_arbiter;

    localparam int N    = 4;
    localparam int HOLD = 8;
    localparam int IDW  = 2;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [N-1:0]   req;
    logic           idle;
    logic [N-1:0]   gnt;
    logic [IDW-1:0] gid;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    bus_park_arbiter #(.N_MASTERS(N), .HOLD_LIMIT(HOLD)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .bus_idle_i (idle),
        .gnt_o      (gnt),
        .gnt_id_o   (gid)
    );

    task automatic tick(int n = 1);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input logic [N-1:0] exp, input string tag);
        checks++;
        if (gnt !== exp) begin
            fails++;
            $display("FAIL %s gnt actual=%b expected=%b", tag, gnt, exp);
        end
    endtask

    task automatic chk_id(input logic [IDW-1:0] exp, input string tag);
        checks++;
        if (gid !== exp) begin
            fails++;
            $display("FAIL %s gnt_id actual=%0d expected=%0d", tag, gid, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req   = '0;
        idle  = 1'b0;
        tick(3);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; req = '0; idle = 1'b0;
        tick(2);
        chk(4'b0001, "R1");
        rst_n = 1'b1;
        tick(2);
        chk(4'b0001, "R1");
        chk_id(2'd0, "R1");
    endtask

    task automatic t_handover();
        do_reset();
        req = 4'b0010; idle = 1'b1;
        tick();
        chk(4'b0001, "R4");
        tick();
        chk(4'b0010, "R4");
        chk_id(2'd1, "R4");
    endtask

    task automatic t_busy();
        do_reset();
        req = 4'b0100; idle = 1'b0;
        tick(4);
        chk(4'b0001, "R3");
        idle = 1'b1;
        tick();
        chk(4'b0100, "R3");
    endtask

    task automatic t_round_robin();
        logic [N-1:0] seq [4];
        seq[0] = 4'b0010; seq[1] = 4'b0100; seq[2] = 4'b1000; seq[3] = 4'b0001;
        do_reset();
        req = 4'b1111; idle = 1'b1;
        tick(2);
        chk(seq[0], "R5");
        for (int i = 1; i < 4; i++) begin
            tick();
            chk(seq[i-1], "R10");
            checks++;
            if ($countones(gnt) > 1) begin
                fails++;
                $display("FAIL R2 gnt actual=%b expected=at most one bit", gnt);
            end
            tick();
            chk(seq[i], "R5");
        end
        do_reset();
        req = 4'b1010; idle = 1'b1;
        tick(2);
        chk(4'b0010, "R5");
        tick(2);
        chk(4'b1000, "R5");
        tick(2);
        chk(4'b0010, "R5");
    endtask

    task automatic t_park();
        do_reset();
        req = 4'b0010; idle = 1'b1;
        tick(2);
        chk(4'b0010, "R6");
        req = 4'b0000;
        tick(5);
        chk(4'b0010, "R6");
        req = 4'b0010; idle = 1'b0;
        tick(HOLD + 3);
        chk(4'b0010, "R6");
    endtask

    task automatic t_stale();
        do_reset();
        req = 4'b0100; idle = 1'b0;
        tick();
        req = 4'b0000; idle = 1'b1;
        tick();
        chk(4'b0001, "R7");
        tick(2);
        chk(4'b0001, "R7");
    endtask

    task automatic t_revoke(input bit restore);
        do_reset();
        req = 4'b0010; idle = 1'b1;
        tick(2);
        chk(4'b0010, "R8");
        req = 4'b0110; idle = 1'b0;
        tick(HOLD);
        chk(4'b0010, "R8");
        tick();
        chk(4'b0000, "R8");
        chk_id(2'd1, "R8");
        tick(3);
        chk(4'b0000, "R8");
        if (restore) begin
            req = 4'b0010; idle = 1'b1;
            tick();
            chk(4'b0010, "R7");
            chk_id(2'd1, "R7");
        end else begin
            idle = 1'b1;
            tick();
            chk(4'b0100, "R9");
            chk_id(2'd2, "R9");
        end
    endtask

    initial begin
        rst_n = 1'b0;
        req   = '0;
        idle  = 1'b0;
        t_reset();
        t_handover();
        t_busy();
        t_round_robin();
        t_park();
        t_stale();
        t_revoke(1'b0);
        t_revoke(1'b1);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=still running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule